// File: doc/BRIEF.md
# Microcode Pattern RAM Debug Access Port

This block holds a 64-word by 32-bit pattern RAM that stores timing words for a programmable bus sequencer. Software reaches the array indirectly through two registers on a small synchronous register bus. The control register carries a two-bit opcode and a six-bit array pointer. The data register is the staging word for array transfers.

In read mode, each single-cycle dummy-cycle strobe latches the array word at the pointer into the data register. The pointer then advances. In write mode, the same strobe stores the data register into the array and also advances the pointer. Software knows a transfer has finished when it sees the pointer move. It may rewrite the pointer before any transfer, so it can visit words in any order. The idle and run opcodes make the strobe do nothing. Executing patterns on an external bus is not part of this block.

Top module: `ucode_dbg_port`

## Requirements
- R1: After reset the control register and the data register both read 0, and every array word reads back as 0.
- R2: Register index 0 is the control register and index 1 is the data register. Read data is combinational from `reg_addr_i`. A write at a clock edge is visible on `reg_rdata_o` in the next cycle. The control register keeps the opcode in bits [29:28] and the pointer in bits [5:0], and its other bits read 0.
- R3: With opcode 2'b10 (read), an accepted strobe loads the array word at the captured pointer into the data register at the first clock edge after the strobe edge.
- R4: The pointer becomes the captured pointer plus one at the second clock edge after the strobe edge, and not before.
- R5: The pointer is 6 bits wide and advances from 63 to 0.
- R6: With opcode 2'b01 (write), an accepted strobe stores the data register into the array word at the captured pointer, and the pointer advances as in R4.
- R7: With opcode 2'b00 (idle) or 2'b11 (run), the strobe changes neither register nor any array word.
- R8: A strobe that arrives during the two cycles after an accepted strobe is ignored. The pointer completion of the first transfer overrides a pointer write made during those cycles.
- R9: Rewriting the pointer between transfers gives read results from non-sequential addresses.
- R10: Register indexes 2 and 3 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 2 | Register index |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| dummy_strb_i | input | 1 | Single-cycle dummy-cycle strobe |

## Verification
Words are first stored with write-mode strobes. Some stores use an explicit pointer and some rely on auto-advance. Reads then visit those words in a scattered order that includes address 63 and a never-written address. This separates a correct address path from one that ignores the pointer or does not wrap.

The control register is sampled one and two cycles after each strobe, which pins the completion latency exactly. Idle-mode and run-mode strobes use a distinctive staging word, so any hidden array write shows up as a corrupted later read. A pointer write followed by a second strobe during the busy window tells a rejected strobe apart from an accepted one.

// File: rtl/ucode_dbg_pkg.sv
package ucode_dbg_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RUN   = 2'b11
  } op_e;

  localparam int unsigned OP_LSB   = 28;
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_DATA = 1;
endpackage

// File: rtl/ucode_dbg_ram.sv
module ucode_dbg_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && (addr_i == ADDR_W'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/ucode_dbg_seq.sv
module ucode_dbg_seq
  import ucode_dbg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strb_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              acc_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              load_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] next_ptr_o
);
  logic              s1_vld_q, s2_vld_q;
  op_e               s1_op_q;
  logic [ADDR_W-1:0] s1_ptr_q, s2_ptr_q;

  assign busy_o = s1_vld_q | s2_vld_q;
  assign acc_o  = strb_i && !busy_o && (op_i == OP_READ || op_i == OP_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_op_q  <= OP_IDLE;
      s1_ptr_q <= '0;
      s2_vld_q <= 1'b0;
      s2_ptr_q <= '0;
    end else begin
      s1_vld_q <= acc_o;
      if (acc_o) begin
        s1_op_q  <= op_i;
        s1_ptr_q <= ptr_i;
      end
      s2_vld_q <= s1_vld_q;
      if (s1_vld_q) s2_ptr_q <= s1_ptr_q;
    end
  end

  // stage 1 touches the array, stage 2 publishes completion via the pointer
  assign ram_addr_o = s1_ptr_q;
  assign ram_we_o   = s1_vld_q && (s1_op_q == OP_WRITE);
  assign load_o     = s1_vld_q && (s1_op_q == OP_READ);
  assign done_o     = s2_vld_q;
  assign next_ptr_o = s2_ptr_q + ADDR_W'(1);
endmodule

// File: rtl/ucode_dbg_regs.sv
module ucode_dbg_regs
  import ucode_dbg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned REG_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] next_ptr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [DATA_W-1:0] data_o
);
  logic wr_ctrl, wr_data;

  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_AW'(REG_CTRL));
  assign wr_data = reg_we_i && (reg_addr_i == REG_AW'(REG_DATA));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= OP_IDLE;
      ptr_o  <= '0;
      data_o <= '0;
    end else begin
      if (wr_ctrl) begin
        op_o  <= op_e'(reg_wdata_i[OP_LSB +: 2]);
        ptr_o <= reg_wdata_i[ADDR_W-1:0];
      end
      if (done_i) ptr_o <= next_ptr_i;       // completion wins over bus write
      if (wr_data) data_o <= reg_wdata_i;
      if (load_i) data_o <= load_data_i;     // array load wins over bus write
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == REG_AW'(REG_CTRL)) begin
      reg_rdata_o[OP_LSB +: 2]  = op_o;
      reg_rdata_o[ADDR_W-1:0]   = ptr_o;
    end else if (reg_addr_i == REG_AW'(REG_DATA)) begin
      reg_rdata_o = data_o;
    end
  end
endmodule

// File: rtl/ucode_dbg_port.sv
module ucode_dbg_port
  import ucode_dbg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned REG_AW = 2,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              dummy_strb_i
);
  op_e               mode_op_q;
  logic [ADDR_W-1:0] mode_ptr_q;
  logic [DATA_W-1:0] data_q;
  logic              acc, busy, ram_we, load, done;
  logic [ADDR_W-1:0] ram_addr, next_ptr;
  logic [DATA_W-1:0] ram_rdata;

  ucode_dbg_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strb_i     (dummy_strb_i),
    .op_i       (mode_op_q),
    .ptr_i      (mode_ptr_q),
    .acc_o      (acc),
    .busy_o     (busy),
    .ram_addr_o (ram_addr),
    .ram_we_o   (ram_we),
    .load_o     (load),
    .done_o     (done),
    .next_ptr_o (next_ptr)
  );

  ucode_dbg_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (data_q),
    .rdata_o (ram_rdata)
  );

  ucode_dbg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .load_i      (load),
    .load_data_i (ram_rdata),
    .done_i      (done),
    .next_ptr_i  (next_ptr),
    .op_o        (mode_op_q),
    .ptr_o       (mode_ptr_q),
    .data_o      (data_q)
  );
endmodule

// File: rtl/ucode_dbg_chk.sv
module ucode_dbg_chk
  import ucode_dbg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned REG_AW = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              strb_i,
  input op_e               op_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              acc_i,
  input logic              busy_i
);
  logic wr_ctrl;
  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_AW'(REG_CTRL));

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (op_i == op_e'($past(reg_wdata_i[OP_LSB +: 2])))); // R2

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !wr_ctrl) |=> $stable(ptr_i)); // R4

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> ##2 (ptr_i == ADDR_W'($past(ptr_i, 3) + 1'b1))); // R5

  AST_IDLE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i && !busy_i && !reg_we_i && (op_i == OP_IDLE || op_i == OP_RUN))
    |=> ($stable(data_i) && $stable(ptr_i) && $stable(op_i))); // R7

  AST_BUSY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> busy_i ##1 busy_i ##1 !busy_i); // R8

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> !acc_i ##1 !acc_i); // R8
endmodule

bind ucode_dbg_port ucode_dbg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .strb_i      (dummy_strb_i),
  .op_i        (mode_op_q),
  .ptr_i       (mode_ptr_q),
  .data_i      (data_q),
  .acc_i       (acc),
  .busy_i      (busy)
);

// File: tb/tb_ucode_dbg_port.sv
module tb_ucode_dbg_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dummy_strb_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  ucode_dbg_port dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_addr_i   (reg_addr_i),
    .reg_we_i     (reg_we_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .dummy_strb_i (dummy_strb_i)
  );

  function automatic logic [31:0] mk(input logic [1:0] op, input int ptr);
    return {2'b00, op, 22'd0, 6'(ptr)};
  endfunction

  function automatic logic [31:0] pat(input int a);
    return {16'hC0DE, 8'(a), ~8'(a)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr_i = a; reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic strobe();
    dummy_strb_i = 1'b1;
    @(negedge clk_i);
    dummy_strb_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
    bus_rd(2'd1, d); chk("R1 data", d, 32'h0);
    bus_wr(2'd0, mk(2'b10, 40));
    bus_wr(2'd1, 32'hFFFF_FFFF);
    strobe(); @(negedge clk_i); @(negedge clk_i);
    bus_rd(2'd1, d); chk("R1 array word 40", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_rd(2'd0, d); chk("R2 ctrl fields", d, 32'h3000_003F);
    bus_wr(2'd1, 32'hA5A5_5A5A);
    bus_rd(2'd1, d); chk("R2 data", d, 32'hA5A5_5A5A);
    bus_wr(2'd2, 32'h1234_5678);
    bus_rd(2'd2, d); chk("R10 idx2", d, 32'h0);
    bus_wr(2'd3, 32'h1234_5678);
    bus_rd(2'd3, d); chk("R10 idx3", d, 32'h0);
    bus_rd(2'd1, d); chk("R10 data untouched", d, 32'hA5A5_5A5A);
    bus_wr(2'd0, 32'h0);
  endtask

  task automatic wr_word(input int a, input bit set_ptr);
    logic [31:0] d;
    bus_wr(2'd1, pat(a));
    if (set_ptr) bus_wr(2'd0, mk(2'b01, a));
    strobe(); @(negedge clk_i); @(negedge clk_i);
    bus_rd(2'd0, d); chk("R6 ptr after write", d, mk(2'b01, (a + 1) % 64));
  endtask

  task automatic t_write();
    wr_word(3, 1'b1);
    wr_word(4, 1'b0);
    wr_word(10, 1'b1);
    wr_word(11, 1'b0);
    wr_word(63, 1'b1);
  endtask

  task automatic rd_word(input int a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_wr(2'd0, mk(2'b10, a));
    bus_wr(2'd1, 32'hDEAD_BEEF);
    strobe();
    bus_rd(2'd0, d); chk("R4 ptr held 1 cycle", d, mk(2'b10, a));
    @(negedge clk_i);
    bus_rd(2'd1, d); chk(tag, d, exp);
    bus_rd(2'd0, d); chk("R4 ptr held 2 cycles", d, mk(2'b10, a));
    @(negedge clk_i);
    bus_rd(2'd0, d); chk("R4 ptr advanced", d, mk(2'b10, (a + 1) % 64));
  endtask

  task automatic t_read_scatter();
    logic [31:0] d;
    rd_word(63, pat(63), "R3 read 63");
    bus_rd(2'd0, d); chk("R5 ptr wrapped", d, mk(2'b10, 0));
    rd_word(10, pat(10), "R9 read 10");
    rd_word(4, pat(4), "R9 read 4");
    rd_word(40, 32'h0, "R9 read 40");
    rd_word(11, pat(11), "R3 read 11");
    rd_word(3, pat(3), "R9 read 3");
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    for (int k = 0; k < 2; k++) begin
      logic [1:0] op = (k == 0) ? 2'b00 : 2'b11;
      bus_wr(2'd0, mk(op, 10));
      bus_wr(2'd1, 32'h0BAD_F00D);
      strobe(); @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
      bus_rd(2'd0, d); chk("R7 ctrl unchanged", d, mk(op, 10));
      bus_rd(2'd1, d); chk("R7 data unchanged", d, 32'h0BAD_F00D);
    end
    rd_word(10, pat(10), "R7 array unchanged");
  endtask

  task automatic t_busy();
    logic [31:0] d;
    bus_wr(2'd0, mk(2'b10, 3));
    dummy_strb_i = 1'b1;
    @(negedge clk_i);
    dummy_strb_i = 1'b0;
    reg_addr_i = 2'd0; reg_we_i = 1'b1; reg_wdata_i = mk(2'b10, 10);
    @(negedge clk_i);
    reg_we_i = 1'b0; dummy_strb_i = 1'b1;
    @(negedge clk_i);
    dummy_strb_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
    bus_rd(2'd0, d); chk("R8 ptr from first transfer", d, mk(2'b10, 4));
    bus_rd(2'd1, d); chk("R8 data from first transfer", d, pat(3));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_write();
    t_read_scatter();
    t_ignore();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule